// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the 32-bit program counter of a simple single-issue RISC core and decides, every cycle, where the next fetch comes from. It looks at the instruction fetched from the current address and at two register operands that the register file supplies. From these it picks one of several sources for the next address. The first is the following word. The second is a word-scaled relative branch target, taken when the operands are equal or taken when they differ, depending on the branch. The third is a region-local absolute jump target. The last is an address held in a register. When the instruction is a call, the block also asks for a register write that saves the return address.

The program counter is a register. The link-write request and the alignment flag are combinational and belong to the instruction presented in the same cycle. A stall input freezes the program counter and suppresses every request. Instruction memory, the register file and the ALU are outside the block. Branch delay slots and exceptions are not modelled.

Top module: `pc_next_unit`

## Requirements
- R1: An active-high synchronous reset sets `pc` to 0 at the next clock edge, whatever the other inputs are.
- R2: For any instruction that is not a control transfer, `pc` advances by 4 and `link_we` stays 0. This covers opcode 0 with a funct other than 0x08 or 0x09.
- R3: A branch-equal is opcode 0x04, with a signed 16-bit word offset in bits 15..0. When `rs_val == rt_val`, the next `pc` is pc+4+(sign-extended offset × 4). Otherwise it is pc+4. An offset of 10 therefore moves 40 bytes beyond pc+4.
- R4: A branch-not-equal is opcode 0x05 and uses the same offset rule. It is taken when `rs_val != rt_val`, and otherwise the next `pc` is pc+4.
- R5: A jump is opcode 0x02. The next `pc` is built from bits 31..28 of the current `pc`, then bits 25..0 of the instruction, then two zero bits. It makes no link request.
- R6: A jump-and-link is opcode 0x03. It jumps as in R5, and in the same cycle it raises `link_we` with `link_idx` = 31 and `link_addr` = pc+4.
- R7: A jump-register is opcode 0 with funct (bits 5..0) 0x08. It loads `pc` with `rs_val` and makes no link request.
- R8: A jump-and-link-register is opcode 0 with funct 0x09. It loads `pc` with `rs_val`, and in the same cycle it raises `link_we` with `link_idx` set to instruction bits 15..11 and `link_addr` = pc+4.
- R9: During an unstalled register jump (R7 or R8) whose `rs_val[1:0]` is nonzero, `align_err` is 1 in that cycle and `pc` still takes `rs_val`. Otherwise `align_err` is 0.
- R10: While `stall` is 1 and reset is 0, `pc` holds its value, and both `link_we` and `align_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze program counter and suppress requests |
| instr | input | 32 | Instruction fetched from the current `pc` |
| rs_val | input | 32 | First register operand (comparison, register jump target) |
| rt_val | input | 32 | Second register operand (comparison) |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Destination register of the return address |
| link_addr | output | 32 | Return address (pc+4) |
| align_err | output | 1 | Register jump target not word aligned |

## Verification
The only state is the program counter, so any wrong choice of next address shows on `pc` one clock after the offending instruction. The error then carries forward into every later address, which makes a single bad branch decision or a bad target field visible at once. A wrong decode or a missed stall shows in the same cycle on `link_we`, `link_idx`, `link_addr` or `align_err`. Random instruction streams are mixed with directed cases to reach these paths: negative offsets, high region bits, misaligned register targets, stalled calls and a reset in the middle of a run.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

    localparam int XLEN   = 32;
    localparam int REGW   = 5;
    localparam int OPW    = 6;
    localparam int IMMW   = 16;
    localparam int TGTW   = 26;
    localparam int REGIONW = XLEN - TGTW - 2;

    localparam logic [OPW-1:0] OP_SPECIAL = 6'h00;
    localparam logic [OPW-1:0] OP_JUMP    = 6'h02;
    localparam logic [OPW-1:0] OP_CALL    = 6'h03;
    localparam logic [OPW-1:0] OP_BR_EQ   = 6'h04;
    localparam logic [OPW-1:0] OP_BR_NE   = 6'h05;
    localparam logic [OPW-1:0] FN_REGJMP  = 6'h08;
    localparam logic [OPW-1:0] FN_REGCALL = 6'h09;

    localparam logic [XLEN-1:0] WORD_STEP = 32'd4;

    typedef enum logic [2:0] {
        XF_SEQ,
        XF_BR_EQ,
        XF_BR_NE,
        XF_JUMP,
        XF_CALL,
        XF_REGJMP,
        XF_REGCALL
    } xfer_e;

    typedef struct packed {
        xfer_e             kind;
        logic [REGW-1:0]   rd;
        logic [IMMW-1:0]   imm;
        logic [TGTW-1:0]   tgt;
    } dec_t;

    function automatic logic [XLEN-1:0] word_disp(input logic [IMMW-1:0] imm);
        return {{(XLEN-IMMW-2){imm[IMMW-1]}}, imm, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] region_target(input logic [XLEN-1:0] cur,
                                                      input logic [TGTW-1:0] tgt);
        return {cur[XLEN-1 -: REGIONW], tgt, 2'b00};
    endfunction

endpackage

// File: rtl/pcnu_decode.sv
module pcnu_decode
    import pcnu_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    logic [OPW-1:0] op;
    logic [OPW-1:0] fn;

    always_comb begin
        op       = instr[XLEN-1 -: OPW];
        fn       = instr[OPW-1:0];
        dec.rd   = instr[15:11];
        dec.imm  = instr[IMMW-1:0];
        dec.tgt  = instr[TGTW-1:0];
        dec.kind = XF_SEQ;
        case (op)
            OP_BR_EQ:   dec.kind = XF_BR_EQ;
            OP_BR_NE:   dec.kind = XF_BR_NE;
            OP_JUMP:    dec.kind = XF_JUMP;
            OP_CALL:    dec.kind = XF_CALL;
            OP_SPECIAL: begin
                if (fn == FN_REGJMP)       dec.kind = XF_REGJMP;
                else if (fn == FN_REGCALL) dec.kind = XF_REGCALL;
            end
            default:    dec.kind = XF_SEQ;
        endcase
    end
endmodule

// File: rtl/pcnu_target.sv
module pcnu_target
    import pcnu_pkg::*;
(
    input  logic [XLEN-1:0] cur_pc,
    input  xfer_e           kind,
    input  logic [IMMW-1:0] imm,
    input  logic [TGTW-1:0] tgt,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] seq_pc,
    output logic            misaligned
);
    logic            same;
    logic [XLEN-1:0] br_pc;

    always_comb begin
        seq_pc     = cur_pc + WORD_STEP;
        br_pc      = seq_pc + word_disp(imm);
        same       = (rs_val == rt_val);
        misaligned = 1'b0;
        case (kind)
            XF_BR_EQ:   next_pc = same  ? br_pc : seq_pc;
            XF_BR_NE:   next_pc = !same ? br_pc : seq_pc;
            XF_JUMP,
            XF_CALL:    next_pc = region_target(cur_pc, tgt);
            XF_REGJMP,
            XF_REGCALL: begin
                next_pc    = rs_val;
                misaligned = |rs_val[1:0];
            end
            default:    next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/pcnu_link.sv
module pcnu_link
    import pcnu_pkg::*;
#(
    parameter logic [REGW-1:0] LINK_REG = 5'd31
) (
    input  xfer_e           kind,
    input  logic [REGW-1:0] rd,
    input  logic            stall,
    input  logic [XLEN-1:0] seq_pc,
    output logic            link_we,
    output logic [REGW-1:0] link_idx,
    output logic [XLEN-1:0] link_addr
);
    always_comb begin
        link_addr = seq_pc;
        link_we   = !stall && (kind == XF_CALL || kind == XF_REGCALL);
        link_idx  = (kind == XF_REGCALL) ? rd : LINK_REG;
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcnu_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter logic [REGW-1:0] LINK_REG = 5'd31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] pc,
    output logic            link_we,
    output logic [REGW-1:0] link_idx,
    output logic [XLEN-1:0] link_addr,
    output logic            align_err
);
    dec_t            dec;
    logic [XLEN-1:0] next_pc;
    logic [XLEN-1:0] seq_pc;
    logic            misaligned;

    pcnu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    pcnu_target u_tgt (
        .cur_pc     (pc),
        .kind       (dec.kind),
        .imm        (dec.imm),
        .tgt        (dec.tgt),
        .rs_val     (rs_val),
        .rt_val     (rt_val),
        .next_pc    (next_pc),
        .seq_pc     (seq_pc),
        .misaligned (misaligned)
    );

    pcnu_link #(.LINK_REG(LINK_REG)) u_lnk (
        .kind      (dec.kind),
        .rd        (dec.rd),
        .stall     (stall),
        .seq_pc    (seq_pc),
        .link_we   (link_we),
        .link_idx  (link_idx),
        .link_addr (link_addr)
    );

    assign align_err = misaligned && !stall;

    always_ff @(posedge clk) begin
        if (rst)        pc <= RESET_PC;
        else if (!stall) pc <= next_pc;
    end
endmodule

// File: rtl/pcnu_checker.sv
module pcnu_checker
    import pcnu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            stall,
    input logic [XLEN-1:0] instr,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic [XLEN-1:0] pc,
    input logic            link_we,
    input logic [REGW-1:0] link_idx,
    input logic [XLEN-1:0] link_addr,
    input logic            align_err
);
    logic [OPW-1:0] c_op, c_fn;
    logic is_rj, is_rc, is_ctl, is_j;
    assign c_op   = instr[31:26];
    assign c_fn   = instr[5:0];
    assign is_rj  = (c_op == 6'h00) && (c_fn == 6'h08);
    assign is_rc  = (c_op == 6'h00) && (c_fn == 6'h09);
    assign is_j   = (c_op == 6'h02);
    assign is_ctl = is_rj || is_rc || (c_op >= 6'h02 && c_op <= 6'h05);

    assert_reset_zero_R1: assert property (@(posedge clk) rst |=> pc == 32'd0);

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall && !is_ctl) |=> pc == $past(pc) + 32'd4);

    assert_jump_region_R5: assert property (@(posedge clk) disable iff (rst)
        (!stall && is_j) |=> pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00});

    assert_call_link_R6: assert property (@(posedge clk) disable iff (rst)
        (!stall && c_op == 6'h03) |-> (link_we && link_idx == 5'd31 && link_addr == pc + 32'd4));

    assert_regjump_R7: assert property (@(posedge clk) disable iff (rst)
        (!stall && (is_rj || is_rc)) |=> pc == $past(rs_val));

    assert_align_flag_R9: assert property (@(posedge clk) disable iff (rst)
        align_err |-> ((is_rj || is_rc) && rs_val[1:0] != 2'b00));

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc));

    assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!link_we && !align_err));
endmodule

bind pc_next_unit pcnu_checker u_chk (.*);

// File: tb/pc_next_unit_test.sv
module pc_next_unit_test;
    logic        clk = 1'b0;
    logic        rst, stall;
    logic [31:0] instr, rs_val, rt_val;
    logic [31:0] pc, link_addr;
    logic        link_we, align_err;
    logic [4:0]  link_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [31:0] mpc;

    always #10 clk = ~clk;

    pc_next_unit uut (
        .clk(clk), .rst(rst), .stall(stall), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .link_we(link_we),
        .link_idx(link_idx), .link_addr(link_addr), .align_err(align_err)
    );

    function automatic logic [31:0] mk_i(logic [5:0] op, logic [15:0] imm);
        return {op, 5'd3, 5'd4, imm};
    endfunction
    function automatic logic [31:0] mk_j(logic [5:0] op, logic [25:0] t);
        return {op, t};
    endfunction
    function automatic logic [31:0] mk_r(logic [4:0] rd, logic [5:0] fn);
        return {6'h00, 5'd7, 5'd0, rd, 5'd0, fn};
    endfunction

    function automatic string req_of(logic [31:0] ins);
        case (ins[31:26])
            6'h04: return "R3";
            6'h05: return "R4";
            6'h02: return "R5";
            6'h03: return "R6";
            6'h00: begin
                if (ins[5:0] == 6'h08) return "R7";
                if (ins[5:0] == 6'h09) return "R8";
                return "R2";
            end
            default: return "R2";
        endcase
    endfunction

    function automatic logic [31:0] model_next(logic [31:0] p, logic [31:0] ins,
                                               logic [31:0] a, logic [31:0] b);
        logic [31:0] s, br;
        s  = p + 32'd4;
        br = s + {{14{ins[15]}}, ins[15:0], 2'b00};
        case (req_of(ins))
            "R3": return (a == b) ? br : s;
            "R4": return (a != b) ? br : s;
            "R5", "R6": return {p[31:28], ins[25:0], 2'b00};
            "R7", "R8": return a;
            default: return s;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(logic r, logic s, logic [31:0] ins, logic [31:0] a, logic [31:0] b);
        string       rq;
        logic        is_link, exp_we, exp_al;
        logic [31:0] nxt;
        @(negedge clk);
        rst = r; stall = s; instr = ins; rs_val = a; rt_val = b;
        #2;
        rq      = req_of(ins);
        is_link = (rq == "R6") || (rq == "R8");
        exp_we  = !s && is_link;
        exp_al  = !s && (rq == "R7" || rq == "R8") && (a[1:0] != 2'b00);
        chk(s ? "R10" : rq, "link_we", {31'd0, link_we}, {31'd0, exp_we});
        if (exp_we) begin
            chk(rq, "link_idx", {27'd0, link_idx}, (rq == "R6") ? 32'd31 : {27'd0, ins[15:11]});
            chk(rq, "link_addr", link_addr, mpc + 32'd4);
        end
        chk(s ? "R10" : "R9", "align_err", {31'd0, align_err}, {31'd0, exp_al});
        nxt = r ? 32'd0 : (s ? mpc : model_next(mpc, ins, a, b));
        @(posedge clk); #2;
        chk(r ? "R1" : (s ? "R10" : rq), "pc", pc, nxt);
        mpc = nxt;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog all-reqs actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, ins, junk;
        void'($urandom(32'd20240611));
        rst = 1'b1; stall = 1'b0; instr = '0; rs_val = '0; rt_val = '0;
        mpc = 32'hX;
        // R1 reset with a jump presented
        step(1'b1, 1'b0, mk_j(6'h02, 26'h155), 32'h0, 32'h0);
        step(1'b1, 1'b0, mk_i(6'h23, 16'h0), 32'h0, 32'h0);
        // R2 plain and opcode-0 arithmetic
        step(1'b0, 1'b0, mk_i(6'h08, 16'h1234), 32'h5, 32'h6);
        step(1'b0, 1'b0, mk_r(5'd9, 6'h20), 32'h5, 32'h5);
        // R3 byte distance 40 encoded as 10, taken and not taken
        step(1'b0, 1'b0, mk_i(6'h04, 16'd10), 32'h77, 32'h77);
        step(1'b0, 1'b0, mk_i(6'h04, 16'd10), 32'h77, 32'h78);
        // R4 negative offset
        step(1'b0, 1'b0, mk_i(6'h05, 16'hFFFE), 32'h1, 32'h2);
        step(1'b0, 1'b0, mk_i(6'h05, 16'hFFFE), 32'h3, 32'h3);
        // R7 move into a high region, then R5 keeps region bits
        step(1'b0, 1'b0, mk_r(5'd0, 6'h08), 32'hA000_0000, 32'h0);
        step(1'b0, 1'b0, mk_j(6'h02, 26'h3FF_FFFF), 32'h0, 32'h0);
        // R6 call
        step(1'b0, 1'b0, mk_j(6'h03, 26'h000_0040), 32'h0, 32'h0);
        // R8 and R9 misaligned register call with rd 5
        step(1'b0, 1'b0, mk_r(5'd5, 6'h09), 32'h0000_1003, 32'h0);
        step(1'b0, 1'b0, mk_r(5'd31, 6'h08), 32'h0000_2002, 32'h0);
        // R10 stalled call and stalled misaligned register jump
        step(1'b0, 1'b1, mk_j(6'h03, 26'h0ABCDE), 32'h0, 32'h0);
        step(1'b0, 1'b1, mk_r(5'd4, 6'h09), 32'h0000_0001, 32'h0);
        step(1'b0, 1'b0, mk_r(5'd0, 6'h08), 32'h0000_4000, 32'h0);
        // random stream
        for (int i = 0; i < 600; i++) begin
            int sel;
            sel = $urandom % 9;
            a = $urandom; b = ($urandom % 2) ? a : $urandom;
            case (sel)
                0: ins = mk_i(6'h23, 16'($urandom));
                1: ins = mk_r(5'($urandom), 6'h20 + 6'($urandom % 4));
                2: ins = mk_i(6'h04, 16'($urandom));
                3: ins = mk_i(6'h05, 16'($urandom));
                4: ins = mk_j(6'h02, 26'($urandom));
                5: ins = mk_j(6'h03, 26'($urandom));
                6: ins = mk_r(5'($urandom), 6'h08);
                7: ins = mk_r(5'($urandom), 6'h09);
                default: begin
                    junk = $urandom;
                    ins  = junk;
                end
            endcase
            if ((sel == 6 || sel == 7) && ($urandom % 4 != 0)) a = a & ~32'd3;
            step(1'b0, (sel == 8) || ($urandom % 16 == 0), ins, a, b);
        end
        // R1 reset in the middle of a run
        step(1'b1, 1'b1, mk_j(6'h02, 26'h1), 32'h0, 32'h0);
        step(1'b0, 1'b0, mk_i(6'h2B, 16'h0), 32'h0, 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule